// File: doc/BRIEF.md
# Banked Memory Access Port

This block is a slave on the internal debug register bus that turns register accesses from a debug port into single transfers on a simple memory bus. Each request carries a 4-bit bank number, taken from the bank-select value the debug port holds, and a 2-bit register index within that bank. That gives a register space of 64 words of 32 bits. Four of these words are live: a transfer-address register, a data window, a control register, and a fixed identification word that reports what kind of port this is.

Every access to the data window starts exactly one memory-bus transfer at the held address. A write to the window becomes a bus write. A read of the window returns the bus read data. The memory bus can stretch a transfer by holding its ready low. For that whole time the port reports busy to the debug port and ignores new requests.

When the control register selects word auto-increment, the held address advances by four after each transfer that completes without error. A debugger can then store a block of n words with one address write followed by n data writes. A bus error response is passed up as a one-cycle error flag alongside the response, so that the debug port's sticky error logic can record it.

Top module: `bkmem_port`

## Requirements
- R1: After reset the port is idle: `dbg_busy_o`, `mem_req_o`, `dbg_rsp_o` and `dbg_err_o` are 0, and the address and control registers read back as 0.
- R2: A request accepted while not busy to bank 0 index 0 (address) or bank 0 index 2 (control) completes in one cycle. `dbg_rsp_o` is high in the cycle after the accepting edge. Reads return the stored value: 32 bits for the address, the low 2 bits for the control mode.
- R3: Bank 15 index 3 reads as `ID_VALUE`. Writes to it change nothing.
- R4: Any bank/index pair other than the four live registers reads as 0 and still gets a response. A write to such a pair leaves the address and control registers unchanged.
- R5: An access to bank 0 index 1 (data window) raises `dbg_busy_o` and `mem_req_o` in the cycle after acceptance. The access presents the held address on `mem_addr_o`, the request direction on `mem_we_o` and, for writes, the request data on `mem_wdata_o`.
- R6: A memory transfer completes at a clock edge where `mem_req_o` and `mem_ready_i` are both high. `dbg_rsp_o` is then high in the next cycle, together with the read data for a read (0 for a write), and busy drops.
- R7: While `mem_ready_i` is low, `mem_req_o` stays high and address, direction and write data hold steady. A transfer with w wait cycles keeps busy high for w+1 cycles.
- R8: Control mode 2'b01 adds 4 to the address after each data-window transfer that completes without error, wrapping modulo 2^32. Modes 2'b00, 2'b10 and 2'b11 leave the address unchanged.
- R9: A transfer ending with `mem_err_i` high gives `dbg_err_o` high for the one response cycle, returns read data 0 and does not advance the address. Without a bus error, `dbg_err_o` stays 0.
- R10: A request presented while busy is ignored: it changes no register and produces no extra response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| dbg_req_i | input | 1 | Request strobe from the debug port |
| dbg_we_i | input | 1 | 1 = write, 0 = read |
| dbg_bank_i | input | 4 | Bank number from the debug port's select register |
| dbg_reg_i | input | 2 | Register index within the bank |
| dbg_wdata_i | input | 32 | Write data |
| dbg_busy_o | output | 1 | Port is busy with a memory transfer |
| dbg_rsp_o | output | 1 | One-cycle response strobe |
| dbg_rdata_o | output | 32 | Read data, valid with the response |
| dbg_err_o | output | 1 | Bus error flag, valid with the response |
| mem_req_o | output | 1 | Memory bus transfer request |
| mem_we_o | output | 1 | Memory bus write enable |
| mem_addr_o | output | 32 | Memory bus byte address |
| mem_wdata_o | output | 32 | Memory bus write data |
| mem_rdata_i | input | 32 | Memory bus read data |
| mem_ready_i | input | 1 | Memory bus transfer complete |
| mem_err_i | input | 1 | Memory bus error, valid with ready |

## Verification
The data window is driven with several patterns:
- a run of three writes in increment mode, which shows whether one address write really covers a whole block and whether each word lands at the next address;
- a read with two wait cycles and a stray request arriving mid-transfer, which separates correct stretching and request rejection from a port that answers early or lets the stray write through;
- a single transfer at the top of the address space, which exposes a wrong wrap;
- an errored write, which tells a port that forwards the error and holds the address apart from one that increments anyway or stores the data;
- a transfer in a reserved control mode, which catches a decoder that treats any non-zero mode as increment.

// File: rtl/bkmem_pkg.sv
`timescale 1ns/1ps
package bkmem_pkg;

    localparam int BANK_W = 4;
    localparam int REG_W  = 2;

    // decoded target of a debug-bus request
    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_ADDR,
        SEL_DATA,
        SEL_CTRL,
        SEL_ID
    } sel_e;

    // control-register increment field
    localparam logic [1:0] INC_WORD = 2'b01;

    typedef enum logic {
        ST_IDLE,
        ST_BUS
    } state_e;

endpackage

// File: rtl/bkmem_decode.sv
`timescale 1ns/1ps
module bkmem_decode
    import bkmem_pkg::*;
#(
    parameter int                BANK_W_P = BANK_W,
    parameter int                REG_W_P  = REG_W,
    parameter logic [BANK_W_P-1:0] ID_BANK = '1,
    parameter logic [REG_W_P-1:0]  ID_REG  = '1
) (
    input  logic [BANK_W_P-1:0] bank_i,
    input  logic [REG_W_P-1:0]  reg_i,
    output sel_e                sel_o
);

    always_comb begin
        sel_o = SEL_NONE;
        if (bank_i == '0) begin
            if (reg_i == REG_W_P'(0))      sel_o = SEL_ADDR;
            else if (reg_i == REG_W_P'(1)) sel_o = SEL_DATA;
            else if (reg_i == REG_W_P'(2)) sel_o = SEL_CTRL;
        end else if (bank_i == ID_BANK && reg_i == ID_REG) begin
            sel_o = SEL_ID;
        end
    end

endmodule

// File: rtl/bkmem_addr_step.sv
`timescale 1ns/1ps
module bkmem_addr_step #(
    parameter int ADDR_W = 32,
    parameter int STEP   = 4
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] next_o
);

    // modulo 2^ADDR_W advance
    assign next_o = addr_i + ADDR_W'(STEP);

endmodule

// File: rtl/bkmem_port.sv
`timescale 1ns/1ps
module bkmem_port
    import bkmem_pkg::*;
#(
    parameter int                ADDR_W   = 32,
    parameter int                DATA_W   = 32,
    parameter int                INC_STEP = 4,
    parameter logic [31:0]       ID_VALUE = 32'h0A50_1C01,
    parameter logic [BANK_W-1:0] ID_BANK  = '1,
    parameter logic [REG_W-1:0]  ID_REG   = '1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              dbg_req_i,
    input  logic              dbg_we_i,
    input  logic [BANK_W-1:0] dbg_bank_i,
    input  logic [REG_W-1:0]  dbg_reg_i,
    input  logic [DATA_W-1:0] dbg_wdata_i,
    output logic              dbg_busy_o,
    output logic              dbg_rsp_o,
    output logic [DATA_W-1:0] dbg_rdata_o,
    output logic              dbg_err_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    input  logic              mem_ready_i,
    input  logic              mem_err_i
);

    typedef struct packed {
        state_e            st;
        logic [ADDR_W-1:0] addr;
        logic [1:0]        mode;
        logic              we;
        logic [DATA_W-1:0] wdata;
        logic              rsp;
        logic [DATA_W-1:0] rdata;
        logic              err;
    } port_t;

    port_t q, d;
    sel_e  sel;
    logic [ADDR_W-1:0] addr_plus;

    bkmem_decode #(
        .BANK_W_P (BANK_W),
        .REG_W_P  (REG_W),
        .ID_BANK  (ID_BANK),
        .ID_REG   (ID_REG)
    ) i_decode (
        .bank_i (dbg_bank_i),
        .reg_i  (dbg_reg_i),
        .sel_o  (sel)
    );

    bkmem_addr_step #(
        .ADDR_W (ADDR_W),
        .STEP   (INC_STEP)
    ) i_step (
        .addr_i (q.addr),
        .next_o (addr_plus)
    );

    always_comb begin
        d       = q;
        d.rsp   = 1'b0;
        d.err   = 1'b0;
        d.rdata = '0;
        unique case (q.st)
            ST_IDLE: begin
                if (dbg_req_i) begin
                    unique case (sel)
                        SEL_ADDR: begin
                            d.rsp = 1'b1;
                            if (dbg_we_i) d.addr  = ADDR_W'(dbg_wdata_i);
                            else          d.rdata = DATA_W'(q.addr);
                        end
                        SEL_CTRL: begin
                            d.rsp = 1'b1;
                            if (dbg_we_i) d.mode  = dbg_wdata_i[1:0];
                            else          d.rdata = DATA_W'(q.mode);
                        end
                        SEL_ID: begin
                            d.rsp = 1'b1;
                            if (!dbg_we_i) d.rdata = DATA_W'(ID_VALUE);
                        end
                        SEL_DATA: begin
                            d.st    = ST_BUS;
                            d.we    = dbg_we_i;
                            d.wdata = dbg_wdata_i;
                        end
                        default: d.rsp = 1'b1;
                    endcase
                end
            end
            ST_BUS: begin
                if (mem_ready_i) begin
                    d.st  = ST_IDLE;
                    d.rsp = 1'b1;
                    d.err = mem_err_i;
                    if (!q.we && !mem_err_i) d.rdata = mem_rdata_i;
                    if (q.mode == INC_WORD && !mem_err_i) d.addr = addr_plus;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            q <= '{st: ST_IDLE, addr: '0, mode: '0, we: 1'b0, wdata: '0,
                   rsp: 1'b0, rdata: '0, err: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign dbg_busy_o  = (q.st == ST_BUS);
    assign dbg_rsp_o   = q.rsp;
    assign dbg_rdata_o = q.rdata;
    assign dbg_err_o   = q.err;
    assign mem_req_o   = (q.st == ST_BUS);
    assign mem_we_o    = q.we;
    assign mem_addr_o  = q.addr;
    assign mem_wdata_o = q.wdata;

    // R2: a register access accepted while idle answers on the next cycle
    a_r2_reg_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dbg_req_i && !dbg_busy_o && sel != SEL_DATA) |=> dbg_rsp_o);

    // R5: a data-window access starts a bus request on the next cycle
    a_r5_bus_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dbg_req_i && !dbg_busy_o && sel == SEL_DATA) |=> (mem_req_o && !dbg_rsp_o));

    // R6: a completed transfer is answered on the next cycle and frees the port
    a_r6_done_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mem_req_o && mem_ready_i) |=> (dbg_rsp_o && !dbg_busy_o));

    // R7: a stretched transfer holds its request and its fields
    a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o)
            && $stable(mem_we_o) && $stable(mem_wdata_o)));

    // R8: word increment after an error-free transfer
    a_r8_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mem_req_o && mem_ready_i && !mem_err_i && q.mode == INC_WORD)
            |=> (mem_addr_o == $past(mem_addr_o) + ADDR_W'(INC_STEP)));

    // R9: an errored transfer keeps the address
    a_r9_err_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mem_req_o && mem_ready_i && mem_err_i) |=> (dbg_err_o && $stable(mem_addr_o)));

    // R9: the error flag only appears with a response
    a_r9_err_with_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dbg_err_o |-> dbg_rsp_o);

    // R10: no response while a transfer is outstanding
    a_r10_quiet_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dbg_busy_o |-> !dbg_rsp_o);

endmodule

// File: tb/test_bkmem_port.sv
`timescale 1ns/1ps
module test_bkmem_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dbg_req = 1'b0;
    logic        dbg_we = 1'b0;
    logic [3:0]  dbg_bank = '0;
    logic [1:0]  dbg_reg = '0;
    logic [31:0] dbg_wdata = '0;
    logic        dbg_busy, dbg_rsp, dbg_err;
    logic [31:0] dbg_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_ready, mem_err;

    int total = 0;
    int bad = 0;

    localparam logic [31:0] ID_EXP = 32'h0A50_1C01;

    // memory model
    logic [31:0] mem [16];
    int          wait_cfg = 0;
    logic        err_cfg = 1'b0;
    int          wcnt = 0;

    always #10 clk = ~clk;

    bkmem_port i_bkmem_port (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .dbg_req_i   (dbg_req),
        .dbg_we_i    (dbg_we),
        .dbg_bank_i  (dbg_bank),
        .dbg_reg_i   (dbg_reg),
        .dbg_wdata_i (dbg_wdata),
        .dbg_busy_o  (dbg_busy),
        .dbg_rsp_o   (dbg_rsp),
        .dbg_rdata_o (dbg_rdata),
        .dbg_err_o   (dbg_err),
        .mem_req_o   (mem_req),
        .mem_we_o    (mem_we),
        .mem_addr_o  (mem_addr),
        .mem_wdata_o (mem_wdata),
        .mem_rdata_i (mem_rdata),
        .mem_ready_i (mem_ready),
        .mem_err_i   (mem_err)
    );

    assign mem_ready = mem_req && (wcnt == wait_cfg);
    assign mem_err   = mem_ready && err_cfg;
    assign mem_rdata = mem[mem_addr[5:2]];

    always @(posedge clk) begin
        if (!mem_req || mem_ready) wcnt <= 0;
        else                       wcnt <= wcnt + 1;
        if (mem_req && mem_ready && mem_we && !err_cfg)
            mem[mem_addr[5:2]] <= mem_wdata;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // single-cycle register access; returns read data
    task automatic reg_acc(input logic we, input logic [3:0] bank, input logic [1:0] rg,
                           input logic [31:0] wd, output logic [31:0] rd);
        @(negedge clk);
        dbg_req = 1'b1; dbg_we = we; dbg_bank = bank; dbg_reg = rg; dbg_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        dbg_req = 1'b0;
        chk("R2 response strobe", {31'b0, dbg_rsp}, 32'd1);
        rd = dbg_rdata;
    endtask

    // data-window access; checks the bus side and returns read data, error, busy cycles
    task automatic data_acc(input logic we, input logic [31:0] wd, input logic [31:0] exp_addr,
                            input logic stray, output logic [31:0] rd, output logic er,
                            output int cyc);
        @(negedge clk);
        dbg_req = 1'b1; dbg_we = we; dbg_bank = 4'd0; dbg_reg = 2'd1; dbg_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        dbg_req = 1'b0;
        chk("R5 busy raised", {31'b0, dbg_busy}, 32'd1);
        chk("R5 mem request", {31'b0, mem_req}, 32'd1);
        chk("R5 mem address", mem_addr, exp_addr);
        chk("R5 mem direction", {31'b0, mem_we}, {31'b0, we});
        if (we) chk("R5 mem write data", mem_wdata, wd);
        if (stray) begin
            dbg_req = 1'b1; dbg_we = 1'b1; dbg_bank = 4'd0; dbg_reg = 2'd0;
            dbg_wdata = 32'hDEAD_0000;
        end
        cyc = 0;
        while (!dbg_rsp && cyc < 50) begin
            if (cyc > 0) begin
                chk("R7 request held", {31'b0, mem_req}, 32'd1);
                chk("R7 address held", mem_addr, exp_addr);
            end
            cyc++;
            @(negedge clk);
            dbg_req = 1'b0;
        end
        chk("R6 response after transfer", {31'b0, dbg_rsp}, 32'd1);
        chk("R6 busy dropped", {31'b0, dbg_busy}, 32'd0);
        rd = dbg_rdata;
        er = dbg_err;
    endtask

    task automatic t_reset();
        logic [31:0] rd;
        chk("R1 busy after reset", {31'b0, dbg_busy}, 32'd0);
        chk("R1 mem_req after reset", {31'b0, mem_req}, 32'd0);
        chk("R1 rsp after reset", {31'b0, dbg_rsp}, 32'd0);
        chk("R1 err after reset", {31'b0, dbg_err}, 32'd0);
        reg_acc(1'b0, 4'd0, 2'd0, '0, rd);
        chk("R1 address reset value", rd, 32'd0);
        reg_acc(1'b0, 4'd0, 2'd2, '0, rd);
        chk("R1 control reset value", rd, 32'd0);
    endtask

    task automatic t_regs();
        logic [31:0] rd;
        reg_acc(1'b1, 4'd0, 2'd0, 32'h0000_1000, rd);
        reg_acc(1'b0, 4'd0, 2'd0, '0, rd);
        chk("R2 address readback", rd, 32'h0000_1000);
        reg_acc(1'b1, 4'd0, 2'd2, 32'hFFFF_FFFD, rd);
        reg_acc(1'b0, 4'd0, 2'd2, '0, rd);
        chk("R2 control readback", rd, 32'd1);
    endtask

    task automatic t_id();
        logic [31:0] rd;
        reg_acc(1'b0, 4'd15, 2'd3, '0, rd);
        chk("R3 id value", rd, ID_EXP);
        reg_acc(1'b1, 4'd15, 2'd3, 32'h1234_5678, rd);
        reg_acc(1'b0, 4'd15, 2'd3, '0, rd);
        chk("R3 id after write", rd, ID_EXP);
    endtask

    task automatic t_unmapped();
        logic [31:0] rd;
        reg_acc(1'b0, 4'd3, 2'd1, '0, rd);
        chk("R4 unmapped read", rd, 32'd0);
        reg_acc(1'b0, 4'd0, 2'd3, '0, rd);
        chk("R4 bank0 idx3 read", rd, 32'd0);
        reg_acc(1'b1, 4'd0, 2'd3, 32'h5555_5555, rd);
        reg_acc(1'b1, 4'd2, 2'd0, 32'h6666_6666, rd);
        reg_acc(1'b1, 4'd1, 2'd2, 32'h0000_0002, rd);
        reg_acc(1'b0, 4'd0, 2'd0, '0, rd);
        chk("R4 address untouched", rd, 32'h0000_1000);
        reg_acc(1'b0, 4'd0, 2'd2, '0, rd);
        chk("R4 control untouched", rd, 32'd1);
    endtask

    task automatic t_block_write();
        logic [31:0] rd;
        logic er;
        int cyc;
        wait_cfg = 0;
        reg_acc(1'b1, 4'd0, 2'd2, 32'd1, rd);
        reg_acc(1'b1, 4'd0, 2'd0, 32'h0000_0020, rd);
        for (int k = 0; k < 3; k++) begin
            data_acc(1'b1, 32'h1111_0001 + k, 32'h20 + 32'(4 * k), 1'b0, rd, er, cyc);
            chk("R9 no error on clean write", {31'b0, er}, 32'd0);
            chk("R6 write response data", rd, 32'd0);
            chk("R7 zero-wait busy cycles", cyc, 32'd1);
        end
        chk("R8 word 0 stored", mem[8], 32'h1111_0001);
        chk("R8 word 1 stored", mem[9], 32'h1111_0002);
        chk("R8 word 2 stored", mem[10], 32'h1111_0003);
        reg_acc(1'b0, 4'd0, 2'd0, '0, rd);
        chk("R8 address after block", rd, 32'h0000_002C);
    endtask

    task automatic t_read_wait();
        logic [31:0] rd;
        logic er;
        int cyc;
        reg_acc(1'b1, 4'd0, 2'd2, 32'd0, rd);
        reg_acc(1'b1, 4'd0, 2'd0, 32'h0000_0024, rd);
        wait_cfg = 2;
        data_acc(1'b0, '0, 32'h24, 1'b1, rd, er, cyc);
        wait_cfg = 0;
        chk("R6 read data", rd, 32'h1111_0002);
        chk("R7 busy cycles with two waits", cyc, 32'd3);
        chk("R9 no error on clean read", {31'b0, er}, 32'd0);
        @(negedge clk);
        chk("R10 no extra response", {31'b0, dbg_rsp}, 32'd0);
        reg_acc(1'b0, 4'd0, 2'd0, '0, rd);
        chk("R10 stray write ignored / R8 mode 0 holds", rd, 32'h0000_0024);
    endtask

    task automatic t_error();
        logic [31:0] rd;
        logic er;
        int cyc;
        reg_acc(1'b1, 4'd0, 2'd2, 32'd1, rd);
        reg_acc(1'b1, 4'd0, 2'd0, 32'h0000_0030, rd);
        err_cfg = 1'b1;
        data_acc(1'b1, 32'hBAD0_BAD0, 32'h30, 1'b0, rd, er, cyc);
        chk("R9 error flagged", {31'b0, er}, 32'd1);
        data_acc(1'b0, '0, 32'h30, 1'b0, rd, er, cyc);
        chk("R9 errored read data", rd, 32'd0);
        err_cfg = 1'b0;
        @(negedge clk);
        chk("R9 error is one cycle", {31'b0, dbg_err}, 32'd0);
        chk("R9 errored write not stored", mem[12], 32'hA000_000C);
        reg_acc(1'b0, 4'd0, 2'd0, '0, rd);
        chk("R9 address held on error", rd, 32'h0000_0030);
    endtask

    task automatic t_wrap();
        logic [31:0] rd;
        logic er;
        int cyc;
        reg_acc(1'b1, 4'd0, 2'd0, 32'hFFFF_FFFC, rd);
        data_acc(1'b1, 32'h7777_7777, 32'hFFFF_FFFC, 1'b0, rd, er, cyc);
        reg_acc(1'b0, 4'd0, 2'd0, '0, rd);
        chk("R8 wrap to zero", rd, 32'h0000_0000);
    endtask

    task automatic t_reserved_mode();
        logic [31:0] rd;
        logic er;
        int cyc;
        reg_acc(1'b1, 4'd0, 2'd2, 32'd2, rd);
        reg_acc(1'b1, 4'd0, 2'd0, 32'h0000_0010, rd);
        data_acc(1'b0, '0, 32'h10, 1'b0, rd, er, cyc);
        chk("R6 read of preset word", rd, 32'hA000_0004);
        reg_acc(1'b0, 4'd0, 2'd0, '0, rd);
        chk("R8 mode 2 no increment", rd, 32'h0000_0010);
        reg_acc(1'b1, 4'd0, 2'd2, 32'd3, rd);
        data_acc(1'b0, '0, 32'h10, 1'b0, rd, er, cyc);
        reg_acc(1'b0, 4'd0, 2'd0, '0, rd);
        chk("R8 mode 3 no increment", rd, 32'h0000_0010);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = 32'hA000_0000 + 32'(i);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_id();
        t_unmapped();
        t_block_write();
        t_read_wait();
        t_error();
        t_wrap();
        t_reserved_mode();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule